// File: doc/BRIEF.md
# ATA PIO Strobe Cycle Sequencer

This block paces host-side programmed I/O cycles for two ATA channels, each with two drives. A small bank of byte-wide timing registers sits behind an indirect port pair. A write on the index port selects a register, and the data port then reads or writes it. Every drive has an address-setup count, an active count and a recovery count in packed encodings. The two drives of the first channel have their own registers. Both drives of the second channel use one shared pair.

A request names a drive and a direction. The sequencer takes a snapshot of that drive's decoded counts and then runs three phases in order: setup, active and recovery. The read or write strobe is high only during the active phase. One clock after recovery ends, a one-cycle done pulse marks the end of the cycle, and the block then accepts the next request. The register bank also holds one prefetch-disable bit per drive and an enable bit for the second channel. These bits are brought out as outputs.

Top module: `pio_strobe_seq`

## Requirements
- R1: A write with `cfg_sel`=0 loads the index. A write with `cfg_sel`=1 writes the register at that index. With `cfg_sel`=1, `cfg_rdata` returns the register at the index, and with `cfg_sel`=0 it returns the index itself. The registers occupy indices 0x50..0x59: config 0x50, control 0x51, command timing 0x52, address timing 0x53/0x55/0x57, read/write timing 0x54/0x56/0x58 and burst 0x59. Any other index reads 0.
- R2: After reset, control reads 0xC0, 0x57 reads 0x0C and all other timing registers read 0x00. Every drive then runs setup 4, active 16 and recovery 16, `pf_dis` is 4'b1111 and `busy` is 0.
- R3: The setup clock count comes from bits 7:6 of the drive's address-timing register: 00 gives 4, 10 gives 3, 01 gives 2 and 11 gives 5.
- R4: The active clock count is bits 7:4 of the drive's read/write timing register, and the value 0 means 16.
- R5: The recovery clock count is bits 3:0 of that register, and the value 0 means 16. When `chip_rev` is greater than 1, recovery lasts one more clock.
- R6: Drive 0 uses registers 0x53/0x54 and drive 1 uses 0x55/0x56. Drives 2 and 3 both use 0x57/0x58.
- R7: `pf_dis[0]` and `pf_dis[1]` are bits 6 and 7 of the control register. `pf_dis[2]` and `pf_dis[3]` are bits 2 and 3 of register 0x57.
- R8: While control bit 3 is 0, a request for drive 2 or 3 is ignored: `busy`, both strobes and `done` stay 0.
- R9: `rd_strobe` is high for read requests and `wr_strobe` for write requests, and only during the active phase. `done` is high for exactly one cycle right after the last recovery cycle, and `busy` is 0 on the cycle after `done`. Requests made while `busy` is 1 are dropped.
- R10: Config bits 1:0 always read `chip_rev`, and writes do not change them. Config bits 7:2 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wr | input | 1 | Write strobe for the selected port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected port |
| chip_rev | input | 2 | Revision value; above 1 it extends recovery |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 2 | Drive number of the request (bit 1 selects the second channel) |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| busy | output | 1 | A cycle is in progress, from acceptance through `done` |
| rd_strobe | output | 1 | Read strobe during the active phase |
| wr_strobe | output | 1 | Write strobe during the active phase |
| done | output | 1 | One-cycle pulse after recovery |
| pf_dis | output | 4 | Prefetch-disable bit per drive |

## Verification
The bench measures the setup, active and recovery lengths of each cycle at the ports. It uses the encodings most likely to be decoded wrongly: nibble 0 as 16, the swapped setup codes 10 and 01, and an active count of 1. A decoder that treated zero as zero, or that read the setup code with its bits in the wrong order, would give phase lengths that differ from the expected ones. Recovery is run with several revision values, so a design that adds the extra clock at the wrong threshold would miss by one. Drives 2 and 3 are run on the shared registers with the second channel first disabled and then enabled, and a request is injected mid-cycle. A design that used per-drive storage on the second channel, honoured disabled requests or restarted while busy would show up as wrong counts or as a spurious busy.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_REGS   = 10;
    localparam int NUM_DRIVES = 4;
    localparam int CNT_W      = 5;
    localparam logic [REG_W-1:0] IDX_BASE = 8'h50;

    // register offsets from IDX_BASE
    localparam int OFF_CFG   = 0;
    localparam int OFF_CTL   = 1;
    localparam int OFF_CMD   = 2;
    localparam int OFF_AT0   = 3;
    localparam int OFF_RW0   = 4;
    localparam int OFF_AT1   = 5;
    localparam int OFF_RW1   = 6;
    localparam int OFF_AT23  = 7;
    localparam int OFF_RW23  = 8;
    localparam int OFF_BURST = 9;

    localparam int CTL_CHAN2_BIT = 3;
    localparam int CTL_PF0_BIT   = 6;
    localparam int REV_W         = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } timing_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(4);
            2'b10:   return CNT_W'(3);
            2'b01:   return CNT_W'(2);
            default: return CNT_W'(5);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] nibble_clocks(input logic [3:0] n);
        return (n == 4'd0) ? CNT_W'(16) : CNT_W'(n);
    endfunction

    function automatic logic [REG_W-1:0] reset_value(input int off);
        if (off == OFF_CTL)  return 8'hC0;
        if (off == OFF_AT23) return 8'h0C;
        return '0;
    endfunction

    function automatic int at_offset(input int drv);
        if (drv == 0) return OFF_AT0;
        if (drv == 1) return OFF_AT1;
        return OFF_AT23;
    endfunction

    function automatic int rw_offset(input int drv);
        if (drv == 0) return OFF_RW0;
        if (drv == 1) return OFF_RW1;
        return OFF_RW23;
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_seq_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NUM_REGS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_sel,
    input  logic                  cfg_wr,
    input  logic [W-1:0]          cfg_wdata,
    input  logic [REV_W-1:0]      chip_rev,
    output logic [W-1:0]          cfg_rdata,
    output logic [W-1:0]          idx_o,
    output logic [N-1:0][W-1:0]   regs_o
);

    typedef struct packed {
        logic [W-1:0]        idx;
        logic [N-1:0][W-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;

    function automatic logic [N-1:0][W-1:0] reset_bank();
        logic [N-1:0][W-1:0] b;
        for (int i = 0; i < N; i++) begin
            b[i] = W'(reset_value(i));
        end
        return b;
    endfunction

    logic [N-1:0] hit;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = (rf_q.idx == W'(int'(IDX_BASE) + i));
        end
    end

    always_comb begin
        rf_d = rf_q;
        if (cfg_wr) begin
            if (!cfg_sel) begin
                rf_d.idx = cfg_wdata;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (hit[i]) begin
                        rf_d.regs[i] = cfg_wdata;
                    end
                end
                rf_d.regs[OFF_CFG][REV_W-1:0] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.idx  <= '0;
            rf_q.regs <= reset_bank();
        end else begin
            rf_q <= rf_d;
        end
    end

    logic [W-1:0] sel_data;

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                sel_data = rf_q.regs[i];
            end
        end
        if (hit[OFF_CFG]) begin
            sel_data[REV_W-1:0] = chip_rev;
        end
        cfg_rdata = cfg_sel ? sel_data : rf_q.idx;
    end

    assign idx_o  = rf_q.idx;
    assign regs_o = rf_q.regs;

endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_seq_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int N      = NUM_REGS,
    parameter int DRIVES = NUM_DRIVES
) (
    input  logic [N-1:0][W-1:0]        regs,
    input  logic [REV_W-1:0]           chip_rev,
    input  logic [$clog2(DRIVES)-1:0]  drive,
    output timing_t                    tim_o,
    output logic [DRIVES-1:0]          pf_dis_o,
    output logic                       chan2_en_o
);

    logic    rec_ext;
    timing_t per_drive [DRIVES];

    assign rec_ext = (chip_rev > REV_W'(1));

    for (genvar d = 0; d < DRIVES; d++) begin : g_drive
        localparam int AT_OFF = at_offset(d);
        localparam int RW_OFF = rw_offset(d);

        assign per_drive[d].setup  = setup_clocks(regs[AT_OFF][7:6]);
        assign per_drive[d].active = nibble_clocks(regs[RW_OFF][7:4]);
        assign per_drive[d].recov  = nibble_clocks(regs[RW_OFF][3:0])
                                     + CNT_W'(rec_ext);

        if (d < 2) begin : g_first
            assign pf_dis_o[d] = regs[OFF_CTL][CTL_PF0_BIT + d];
        end else begin : g_second
            assign pf_dis_o[d] = regs[OFF_AT23][d];
        end
    end

    assign tim_o      = per_drive[drive];
    assign chan2_en_o = regs[OFF_CTL][CTL_CHAN2_BIT];

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    start_write,
    input  timing_t tim,
    output logic    busy,
    output logic    rd_strobe,
    output logic    wr_strobe,
    output logic    done
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
        logic             wr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_SETUP;
                    s_d.cnt = tim.setup - CNT_W'(1);
                    s_d.act = tim.active;
                    s_d.rec = tim.recov;
                    s_d.wr  = start_write;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_ACTIVE;
                    s_d.cnt = s_q.act - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_RECOV;
                    s_d.cnt = s_q.rec - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_DONE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, act: '0, rec: '0, wr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.ph != PH_IDLE);
    assign rd_strobe = (s_q.ph == PH_ACTIVE) && !s_q.wr;
    assign wr_strobe = (s_q.ph == PH_ACTIVE) &&  s_q.wr;
    assign done      = (s_q.ph == PH_DONE);

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [1:0]  chip_rev,
    input  logic        req_valid,
    input  logic [1:0]  req_drive,
    input  logic        req_write,
    output logic        busy,
    output logic        rd_strobe,
    output logic        wr_strobe,
    output logic        done,
    output logic [3:0]  pf_dis
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0]               cfg_idx;
    timing_t                        tim;
    logic                           chan2_en;
    logic                           req_ok;
    logic                           start;

    pio_cfg_regs #(.W(REG_W), .N(NUM_REGS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .chip_rev  (chip_rev),
        .cfg_rdata (cfg_rdata),
        .idx_o     (cfg_idx),
        .regs_o    (regs)
    );

    pio_timing_sel #(.W(REG_W), .N(NUM_REGS), .DRIVES(NUM_DRIVES)) i_sel (
        .regs       (regs),
        .chip_rev   (chip_rev),
        .drive      (req_drive),
        .tim_o      (tim),
        .pf_dis_o   (pf_dis),
        .chan2_en_o (chan2_en)
    );

    assign req_ok = !req_drive[1] || chan2_en;
    assign start  = req_valid && req_ok && !busy;

    pio_phase_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_write (req_write),
        .tim         (tim),
        .busy        (busy),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .done        (done)
    );

endmodule

// File: rtl/pio_strobe_seq_chk.sv
module pio_strobe_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_drive,
    input logic       busy,
    input logic       rd_strobe,
    input logic       wr_strobe,
    input logic       done,
    input logic       chan2_en,
    input logic       cfg_sel,
    input logic [7:0] cfg_idx,
    input logic [7:0] cfg_rdata,
    input logic [1:0] chip_rev
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe)); // R9

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> (busy && !done)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_RECOV_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strobe || wr_strobe) |-> (busy && !done)); // R5

    AST_CHAN2_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_drive[1] && !chan2_en) |=> !busy); // R8

    AST_CFG_REV_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_idx == 8'h50) |-> (cfg_rdata[1:0] == chip_rev)); // R10

endmodule

bind pio_strobe_seq pio_strobe_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_drive (req_drive),
    .busy      (busy),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .done      (done),
    .chan2_en  (chan2_en),
    .cfg_sel   (cfg_sel),
    .cfg_idx   (cfg_idx),
    .cfg_rdata (cfg_rdata),
    .chip_rev  (chip_rev)
);

// File: tb/test_pio_strobe_seq.sv
`timescale 1ns/1ps
module test_pio_strobe_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sel = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [1:0] chip_rev = 2'd1;
    logic       req_valid = 1'b0;
    logic [1:0] req_drive = '0;
    logic       req_write = 1'b0;
    logic       busy, rd_strobe, wr_strobe, done;
    logic [3:0] pf_dis;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pio_strobe_seq i_pio_strobe_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .chip_rev  (chip_rev),
        .req_valid (req_valid),
        .req_drive (req_drive),
        .req_write (req_write),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .done      (done),
        .pf_dis    (pf_dis)
    );

    // {drive[2], write[1], rev[2], at[8], rw[8], setup[5], active[5], recov[5]}
    localparam int NVEC = 7;
    localparam logic [35:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 2'd1, 8'h00, 8'h00, 5'd4, 5'd16, 5'd16},
        {2'd0, 1'b1, 2'd1, 8'h80, 8'h32, 5'd3, 5'd3,  5'd2 },
        {2'd1, 1'b0, 2'd2, 8'h40, 8'h21, 5'd2, 5'd2,  5'd2 },
        {2'd1, 1'b1, 2'd3, 8'hC0, 8'hF0, 5'd5, 5'd15, 5'd17},
        {2'd2, 1'b0, 2'd1, 8'h8C, 8'h45, 5'd3, 5'd4,  5'd5 },
        {2'd3, 1'b1, 2'd2, 8'h4C, 8'h1F, 5'd2, 5'd1,  5'd16},
        {2'd3, 1'b0, 2'd0, 8'h0C, 8'h00, 5'd4, 5'd16, 5'd16}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b1; cfg_wdata = idx;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_sel = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] val);
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b1; cfg_wdata = idx;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_sel = 1'b1;
        #1 val = cfg_rdata;
        cfg_sel = 1'b0;
    endtask

    task automatic run_req(input logic [1:0] drv, input logic wrt, input bit poke,
                           output int s, output int a, output int r, output bit type_ok);
        s = 0; a = 0; r = 0; type_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_drive = drv; req_write = wrt;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            if (rd_strobe || wr_strobe) begin
                a++;
                if (wrt ? (!wr_strobe || rd_strobe) : (!rd_strobe || wr_strobe)) type_ok = 1'b0;
            end else if (a == 0) begin
                s++;
            end else begin
                r++;
            end
            if (poke && k == 2) begin
                req_valid = 1'b1; req_drive = drv ^ 2'b01;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rv;
        int s, a, r;
        bit tok;
        logic [1:0] d;
        logic [7:0] at_idx, rw_idx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy after reset", busy, 0);
        chk(pf_dis == 4'b1111, "R2 pf_dis reset", pf_dis, 15);
        reg_read(8'h51, rv); chk(rv == 8'hC0, "R2 control reset", rv, 8'hC0);
        reg_read(8'h57, rv); chk(rv == 8'h0C, "R2 shared addr timing reset", rv, 8'h0C);
        reg_read(8'h56, rv); chk(rv == 8'h00, "R2 rw timing reset", rv, 0);
        chip_rev = 2'd1;
        run_req(2'd1, 1'b0, 1'b0, s, a, r, tok);
        chk(s == 4 && a == 16 && r == 16, "R2 default phase lengths",
            s * 10000 + a * 100 + r, 41616);

        // R8 second channel disabled: request ignored
        @(negedge clk);
        req_valid = 1'b1; req_drive = 2'd2; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 25; k++) begin
                if (busy || rd_strobe || wr_strobe || done) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R8 disabled channel request ignored", seen, 0);
        end

        // enable second channel, keep prefetch bits
        reg_write(8'h51, 8'hC8);

        // R3 R4 R5 R6 vector table
        for (int v = 0; v < NVEC; v++) begin
            d = VEC[v][35:34];
            at_idx = (d == 2'd0) ? 8'h53 : (d == 2'd1) ? 8'h55 : 8'h57;
            rw_idx = (d == 2'd0) ? 8'h54 : (d == 2'd1) ? 8'h56 : 8'h58;
            reg_write(at_idx, VEC[v][30:23]);
            reg_write(rw_idx, VEC[v][22:15]);
            chip_rev = VEC[v][32:31];
            run_req(d, VEC[v][33], 1'b0, s, a, r, tok);
            chk(s == int'(VEC[v][14:10]), $sformatf("R3 setup vec%0d", v), s, VEC[v][14:10]);
            chk(a == int'(VEC[v][9:5]),   $sformatf("R4 active vec%0d", v), a, VEC[v][9:5]);
            chk(r == int'(VEC[v][4:0]),   $sformatf("R5 recovery vec%0d", v), r, VEC[v][4:0]);
            chk(tok, $sformatf("R9 strobe direction vec%0d", v), tok, 1);
            @(negedge clk);
            chk(!busy && !done, $sformatf("R9 idle after done vec%0d", v), busy, 0);
        end

        // R6 drive 1 unaffected by drive 0 registers
        reg_write(8'h53, 8'hC0);
        reg_write(8'h54, 8'h11);
        reg_write(8'h55, 8'h00);
        reg_write(8'h56, 8'h00);
        chip_rev = 2'd1;
        run_req(2'd1, 1'b1, 1'b0, s, a, r, tok);
        chk(s == 4 && a == 16 && r == 16, "R6 drive1 own registers",
            s * 10000 + a * 100 + r, 41616);
        run_req(2'd0, 1'b1, 1'b0, s, a, r, tok);
        chk(s == 5 && a == 1 && r == 1, "R6 drive0 own registers",
            s * 10000 + a * 100 + r, 50101);

        // R6 drives 2 and 3 share one pair
        reg_write(8'h57, 8'h8C);
        reg_write(8'h58, 8'h23);
        run_req(2'd2, 1'b0, 1'b0, s, a, r, tok);
        chk(s == 3 && a == 2 && r == 3, "R6 drive2 shared", s * 10000 + a * 100 + r, 30203);
        run_req(2'd3, 1'b0, 1'b0, s, a, r, tok);
        chk(s == 3 && a == 2 && r == 3, "R6 drive3 shared", s * 10000 + a * 100 + r, 30203);

        // R9 request while busy is dropped
        reg_write(8'h53, 8'h80);
        reg_write(8'h54, 8'h33);
        run_req(2'd0, 1'b0, 1'b1, s, a, r, tok);
        chk(s == 3 && a == 3 && r == 3, "R9 mid-cycle request dropped",
            s * 10000 + a * 100 + r, 30303);
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (busy) extra++;
            end
            chk(extra == 0, "R9 no second cycle after busy request", extra, 0);
        end

        // R7 prefetch-disable bit placement
        reg_write(8'h51, 8'h48);
        reg_write(8'h57, 8'h08);
        @(negedge clk);
        chk(pf_dis == 4'b1001, "R7 pf_dis mapping", pf_dis, 9);

        // R1 indirect access
        reg_write(8'h59, 8'h40);
        reg_read(8'h59, rv); chk(rv == 8'h40, "R1 burst readback", rv, 8'h40);
        reg_read(8'h5A, rv); chk(rv == 8'h00, "R1 out of range reads 0", rv, 0);
        reg_write(8'h52, 8'hA5);
        reg_read(8'h52, rv); chk(rv == 8'hA5, "R1 command timing readback", rv, 8'hA5);
        @(negedge clk);
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 8'h52, "R1 index port readback", cfg_rdata, 8'h52);

        // R10 revision bits read-only
        reg_write(8'h50, 8'hFF);
        chip_rev = 2'd2;
        reg_read(8'h50, rv); chk(rv == 8'hFE, "R10 config with rev 2", rv, 8'hFE);
        chip_rev = 2'd1;
        reg_read(8'h50, rv); chk(rv == 8'hFD, "R10 config with rev 1", rv, 8'hFD);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule